// File: doc/BRIEF.md
# Stream-Partitioned Translation Cache

This block caches page-table entries for an address-translation unit whose requesters are split into numbered streams. It holds two independent entry arrays: the upper array caches first-level entries, tagged by virtual address bits [31:22], and the lower array caches second-level entries, tagged by bits [21:12]. Every entry stores a valid flag, a 10-bit key and a 32-bit frame number.

Each array's capacity is divided among up to 16 streams by start-address registers. A stream looks up and allocates only inside its own contiguous slice, so heavy traffic from one stream can never push out another stream's entries. A lookup presents an array select, a stream number and a virtual address, and returns hit and frame number in the same cycle. A fill writes a new entry into the stream's slice at a victim chosen by that stream's round-robin pointer. The page-table walk and any memory access are handled by the surrounding logic.

Configuration arrives as simple register writes. One offset invalidates both arrays. Two banks of 16 word-aligned registers hold the slice starts. A start value above the array's largest legal block address is refused and raises a sticky error flag.

Top module: `stream_xlat_cache`

## Requirements
- R1: After reset every entry of both arrays is invalid, every slice start is 0 and `cfg_err` is 0. With all starts at 0, stream 15 owns the whole of each array and streams 0 to 14 own nothing.
- R2: `lk_arr`/`fl_arr` = 0 selects the upper array, keyed by address bits [31:22]. A value of 1 selects the lower array, keyed by bits [21:12]. An entry filled in one array is never returned by a lookup of the other.
- R3: A lookup gives `lk_hit` and `lk_frame` combinationally in the cycle it is presented. A fill becomes visible from the cycle after the clock edge that takes it.
- R4: Stream i owns the entries from its start up to, but not including, the start of stream i+1. Stream 15 owns the entries up to the last one (index 31). When the end is not above the start the slice is empty: a fill there is dropped and a lookup misses.
- R5: A lookup compares only the entries inside the requesting stream's slice. A matching key held in another stream's slice gives a miss.
- R6: Fills within a slice use a round-robin victim that steps through start, start+1, … end-1 and then wraps. A slice of N entries therefore keeps the latest N fills, and fill N+1 evicts the oldest. If the pointer falls outside a slice that has been resized, the victim is the slice start.
- R7: A fill by one stream never invalidates or replaces an entry in another stream's slice.
- R8: Write offsets (`cfg_addr`, byte addresses): 0x00 invalidates. 0x0C+4*i sets the upper-array start of stream i. 0x4C+4*i sets the lower-array start of stream i. Writes to any other offset, including offsets that are not word-aligned, have no effect.
- R9: A start write whose data exceeds the largest legal block address (31 by default) leaves the old start in place and sets `cfg_err`. `cfg_err` then stays at 1 until reset. A write of exactly 31 is accepted.
- R10: A write to offset 0x00, whatever its data, clears the valid flag of every entry in both arrays. It takes priority over a fill in the same cycle, which is dropped.
- R11: A lookup in the same cycle as a fill of the same key returns the contents from before the fill.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 8 | Configuration byte offset |
| cfg_wdata | input | 32 | Configuration write data |
| cfg_err | output | 1 | Sticky flag for a refused start write |
| lk_arr | input | 1 | Lookup array select (0 upper, 1 lower) |
| lk_stream | input | 4 | Lookup stream number |
| lk_vaddr | input | 32 | Lookup virtual address |
| lk_hit | output | 1 | Lookup hit |
| lk_frame | output | 32 | Frame number of the hit entry (0 on a miss) |
| fl_en | input | 1 | Fill strobe |
| fl_arr | input | 1 | Fill array select (0 upper, 1 lower) |
| fl_stream | input | 4 | Fill stream number |
| fl_vaddr | input | 32 | Fill virtual address |
| fl_frame | input | 32 | Frame number to store |

## Verification
The bench builds the block with its default parameters: 16 streams, 32 entries per array and a largest legal start of 31. It programs the upper array into slices of 4, 2 and 2 entries, a run of empty slices, and a 24-entry slice for stream 15. This makes wrap-around eviction in small slices, isolation between neighbours and dropped fills in empty slices easy to observe with a handful of keys. The lower array is first used in its reset layout and then re-split at entry 16. This exposes the end-of-array boundary for stream 15, a refused start value of 32 against an accepted 31, and the effect of moving a slice over entries that are already filled.

// File: rtl/xc_pkg.sv
package xc_pkg;
  localparam int VA_W   = 32;
  localparam int KEY_W  = 10;
  localparam int UP_LSB = 22;
  localparam int LO_LSB = 12;

  // Select which virtual-address field forms the tag of the chosen array.
  function automatic logic [KEY_W-1:0] key_of(input logic arr, input logic [VA_W-1:0] va);
    return arr ? va[LO_LSB +: KEY_W] : va[UP_LSB +: KEY_W];
  endfunction
endpackage

// File: rtl/xc_slice_map.sv
module xc_slice_map #(
  parameter int NS      = 16,
  parameter int SW      = 6,
  parameter int BASE    = 'h0C,
  parameter int MAX_BLK = 31,
  parameter int AW      = 8,
  parameter int DW      = 32
)(
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  cfg_we,
  input  logic [AW-1:0]         cfg_addr,
  input  logic [DW-1:0]         cfg_wdata,
  output logic [NS-1:0][SW-1:0] starts,
  output logic                  bad_wr
);
  localparam int SIW = $clog2(NS);

  int             off;
  logic           sel;
  logic [SIW-1:0] idx;

  always_comb begin
    off = int'(cfg_addr) - BASE;
    sel = cfg_we && (off >= 0) && (off < 4 * NS) && (off[1:0] == 2'b00);
    idx = off[SIW+1:2];
  end

  assign bad_wr = sel && (cfg_wdata > DW'(MAX_BLK));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      starts <= '0;
    else if (sel && !bad_wr)
      starts[idx] <= cfg_wdata[SW-1:0];
  end
endmodule

// File: rtl/xc_tag_array.sv
module xc_tag_array #(
  parameter int NS = 16,
  parameter int NE = 32,
  parameter int SW = 6,
  parameter int KW = 10,
  parameter int FW = 32
)(
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   inv,
  input  logic [NS-1:0][SW-1:0]  starts,
  input  logic [$clog2(NS)-1:0]  lk_stream,
  input  logic [KW-1:0]          lk_key,
  output logic                   lk_hit,
  output logic [FW-1:0]          lk_data,
  input  logic                   fl_en,
  input  logic [$clog2(NS)-1:0]  fl_stream,
  input  logic [KW-1:0]          fl_key,
  input  logic [FW-1:0]          fl_data,
  output logic                   fill_do,
  output logic [$clog2(NE)-1:0]  fill_idx
);
  localparam int IW  = $clog2(NE);
  localparam int SIW = $clog2(NS);

  // Slice end: next stream's start, or the array size for the last stream.
  function automatic logic [SW-1:0] end_of(input logic [NS-1:0][SW-1:0] st,
                                           input logic [SIW-1:0] s);
    if (s == SIW'(NS - 1)) return SW'(NE);
    return st[s + 1'b1];
  endfunction

  function automatic logic in_slice(input int k, input logic [SW-1:0] lo,
                                    input logic [SW-1:0] hi);
    return (SW'(k) >= lo) && (SW'(k) < hi);
  endfunction

  logic [NE-1:0]         ent_v;
  logic [NE-1:0][KW-1:0] ent_k;
  logic [NE-1:0][FW-1:0] ent_d;
  logic [NS-1:0][SW-1:0] rr_ptr;

  logic [SW-1:0] ls, le, fs, fe, cand, fpos, nxt;

  // Lookup: lowest matching index inside the requester's slice wins.
  always_comb begin
    ls = starts[lk_stream];
    le = end_of(starts, lk_stream);
    lk_hit  = 1'b0;
    lk_data = '0;
    for (int k = NE - 1; k >= 0; k--) begin
      if (ent_v[k] && (ent_k[k] == lk_key) && in_slice(k, ls, le)) begin
        lk_hit  = 1'b1;
        lk_data = ent_d[k];
      end
    end
  end

  // Victim selection from the stream's round-robin pointer.
  always_comb begin
    fs      = starts[fl_stream];
    fe      = end_of(starts, fl_stream);
    cand    = fs + rr_ptr[fl_stream];
    fill_do = fl_en && !inv && (fe > fs);
    fpos    = (cand < fe) ? cand : fs;
    nxt     = ((fpos + 1'b1) >= fe) ? '0 : (fpos + 1'b1 - fs);
  end

  assign fill_idx = fpos[IW-1:0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ent_v  <= '0;
      rr_ptr <= '0;
    end else if (inv) begin
      ent_v <= '0;
    end else if (fill_do) begin
      ent_v[fill_idx]   <= 1'b1;
      rr_ptr[fl_stream] <= nxt;
    end
  end

  always_ff @(posedge clk) begin
    if (fill_do) begin
      ent_k[fill_idx] <= fl_key;
      ent_d[fill_idx] <= fl_data;
    end
  end
endmodule

// File: rtl/stream_xlat_cache.sv
module stream_xlat_cache
  import xc_pkg::*;
#(
  parameter int NS         = 16,
  parameter int NE         = 32,
  parameter int FW         = 32,
  parameter int AW         = 8,
  parameter int BASE_UP    = 'h0C,
  parameter int BASE_LO    = 'h4C,
  parameter int INV_ADDR   = 'h00,
  parameter int MAX_BLK_UP = 31,
  parameter int MAX_BLK_LO = 31
)(
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  cfg_we,
  input  logic [AW-1:0]         cfg_addr,
  input  logic [31:0]           cfg_wdata,
  output logic                  cfg_err,
  input  logic                  lk_arr,
  input  logic [$clog2(NS)-1:0] lk_stream,
  input  logic [VA_W-1:0]       lk_vaddr,
  output logic                  lk_hit,
  output logic [FW-1:0]         lk_frame,
  input  logic                  fl_en,
  input  logic                  fl_arr,
  input  logic [$clog2(NS)-1:0] fl_stream,
  input  logic [VA_W-1:0]       fl_vaddr,
  input  logic [FW-1:0]         fl_frame
);
  localparam int IW = $clog2(NE);
  localparam int SW = IW + 1;

  // Named internal events, also observed by the bound checker.
  logic                        inv_pulse;
  logic [KEY_W-1:0]            lk_key, fl_key;
  logic [1:0][NS-1:0][SW-1:0]  starts_a;
  logic [1:0]                  bad_a, hit_a, fdo_a, fl_en_a;
  logic [1:0][FW-1:0]          dat_a;
  logic [1:0][IW-1:0]          fidx_a;

  assign inv_pulse = cfg_we && (cfg_addr == AW'(INV_ADDR));
  assign lk_key    = key_of(lk_arr, lk_vaddr);
  assign fl_key    = key_of(fl_arr, fl_vaddr);

  for (genvar g = 0; g < 2; g++) begin : g_lvl
    localparam int BASE_G = (g == 0) ? BASE_UP : BASE_LO;
    localparam int MAX_G  = (g == 0) ? MAX_BLK_UP : MAX_BLK_LO;

    assign fl_en_a[g] = fl_en && (fl_arr == 1'(g));

    xc_slice_map #(
      .NS(NS), .SW(SW), .BASE(BASE_G), .MAX_BLK(MAX_G), .AW(AW), .DW(32)
    ) u_map (
      .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
      .cfg_wdata(cfg_wdata), .starts(starts_a[g]), .bad_wr(bad_a[g])
    );

    xc_tag_array #(
      .NS(NS), .NE(NE), .SW(SW), .KW(KEY_W), .FW(FW)
    ) u_arr (
      .clk(clk), .rst_n(rst_n), .inv(inv_pulse), .starts(starts_a[g]),
      .lk_stream(lk_stream), .lk_key(lk_key), .lk_hit(hit_a[g]), .lk_data(dat_a[g]),
      .fl_en(fl_en_a[g]), .fl_stream(fl_stream), .fl_key(fl_key), .fl_data(fl_frame),
      .fill_do(fdo_a[g]), .fill_idx(fidx_a[g])
    );
  end

  assign lk_hit   = hit_a[lk_arr];
  assign lk_frame = dat_a[lk_arr];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      cfg_err <= 1'b0;
    else if (|bad_a)
      cfg_err <= 1'b1;
  end
endmodule

// File: rtl/xc_checker.sv
module xc_checker
  import xc_pkg::*;
#(
  parameter int NS = 16,
  parameter int NE = 32,
  parameter int SW = 6,
  parameter int IW = 5
)(
  input logic                       clk,
  input logic                       rst_n,
  input logic                       cfg_we,
  input logic                       cfg_err,
  input logic                       inv_pulse,
  input logic [1:0]                 bad_a,
  input logic [1:0]                 fdo_a,
  input logic [1:0][IW-1:0]         fidx_a,
  input logic [1:0][NS-1:0][SW-1:0] starts_a,
  input logic                       fl_arr,
  input logic [$clog2(NS)-1:0]      fl_stream,
  input logic [VA_W-1:0]            fl_vaddr,
  input logic                       lk_arr,
  input logic [$clog2(NS)-1:0]      lk_stream,
  input logic [VA_W-1:0]            lk_vaddr,
  input logic                       lk_hit
);
  logic             fdo_sel;
  logic [KEY_W-1:0] fkey, lkey;
  assign fdo_sel = fdo_a[fl_arr];
  assign fkey    = key_of(fl_arr, fl_vaddr);
  assign lkey    = key_of(lk_arr, lk_vaddr);

  p_err_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_err |=> cfg_err);

  p_err_set_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (|bad_a) |=> cfg_err);

  p_keep_up_r9: assert property (@(posedge clk) disable iff (!rst_n)
    bad_a[0] |=> $stable(starts_a[0]));

  p_keep_lo_r9: assert property (@(posedge clk) disable iff (!rst_n)
    bad_a[1] |=> $stable(starts_a[1]));

  p_inv_clear_r10: assert property (@(posedge clk) disable iff (!rst_n)
    inv_pulse |=> !lk_hit);

  p_fill_visible_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(fdo_sel) && !$past(cfg_we) && (lk_arr == $past(fl_arr)) &&
     (lk_stream == $past(fl_stream)) && (lkey == $past(fkey))) |-> lk_hit);

  for (genvar g = 0; g < 2; g++) begin : g_chk
    p_fill_in_slice_r4: assert property (@(posedge clk) disable iff (!rst_n)
      fdo_a[g] |-> ((SW'(fidx_a[g]) >= starts_a[g][fl_stream]) &&
                    (SW'(fidx_a[g]) < ((fl_stream == $clog2(NS)'(NS - 1)) ?
                                       SW'(NE) : starts_a[g][fl_stream + 1'b1]))));
  end
endmodule

bind stream_xlat_cache xc_checker #(.NS(NS), .NE(NE), .SW(SW), .IW(IW)) u_chk (
  .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_err(cfg_err),
  .inv_pulse(inv_pulse), .bad_a(bad_a), .fdo_a(fdo_a), .fidx_a(fidx_a),
  .starts_a(starts_a), .fl_arr(fl_arr), .fl_stream(fl_stream), .fl_vaddr(fl_vaddr),
  .lk_arr(lk_arr), .lk_stream(lk_stream), .lk_vaddr(lk_vaddr), .lk_hit(lk_hit)
);

// File: tb/tb_stream_xlat_cache.sv
module tb_stream_xlat_cache;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [7:0]  cfg_addr = '0;
  logic [31:0] cfg_wdata = '0;
  logic        cfg_err;
  logic        lk_arr = 1'b0;
  logic [3:0]  lk_stream = '0;
  logic [31:0] lk_vaddr = '0;
  logic        lk_hit;
  logic [31:0] lk_frame;
  logic        fl_en = 1'b0;
  logic        fl_arr = 1'b0;
  logic [3:0]  fl_stream = '0;
  logic [31:0] fl_vaddr = '0;
  logic [31:0] fl_frame = '0;

  int n_chk = 0;
  int n_bad = 0;

  always #5 clk = ~clk;

  stream_xlat_cache dut (.*);

  typedef struct packed {
    logic       look;   // 0 fill, 1 lookup check
    logic [3:0] s;
    logic [9:0] key;
    logic       eh;
  } vec_t;

  // Upper array, layout: s0 [0,4) s1 [4,6) s2 [6,8) s3..s14 empty s15 [8,32)
  localparam int NV = 24;
  localparam vec_t VECS [NV] = '{
    '{1'b0, 4'd1,  10'h11, 1'b0},  // R3 fill
    '{1'b1, 4'd1,  10'h11, 1'b1},  // R3 hit next cycle
    '{1'b1, 4'd0,  10'h11, 1'b0},  // R5 neighbour miss
    '{1'b1, 4'd15, 10'h11, 1'b0},  // R5 last stream miss
    '{1'b0, 4'd1,  10'h12, 1'b0},
    '{1'b0, 4'd1,  10'h13, 1'b0},  // R6 wraps, evicts 0x11
    '{1'b1, 4'd1,  10'h11, 1'b0},  // R6
    '{1'b1, 4'd1,  10'h12, 1'b1},
    '{1'b1, 4'd1,  10'h13, 1'b1},
    '{1'b0, 4'd0,  10'h20, 1'b0},
    '{1'b0, 4'd1,  10'h14, 1'b0},
    '{1'b0, 4'd1,  10'h15, 1'b0},
    '{1'b0, 4'd1,  10'h16, 1'b0},
    '{1'b1, 4'd0,  10'h20, 1'b1},  // R7 survives neighbour fills
    '{1'b1, 4'd1,  10'h16, 1'b1},
    '{1'b1, 4'd1,  10'h14, 1'b0},  // R6 keeps latest two
    '{1'b0, 4'd5,  10'h30, 1'b0},  // R4 empty slice
    '{1'b1, 4'd5,  10'h30, 1'b0},  // R4
    '{1'b1, 4'd15, 10'h30, 1'b0},  // R4 fill dropped
    '{1'b0, 4'd0,  10'h21, 1'b0},
    '{1'b0, 4'd0,  10'h22, 1'b0},
    '{1'b0, 4'd0,  10'h23, 1'b0},
    '{1'b0, 4'd0,  10'h24, 1'b0},  // R6 four-entry wrap evicts 0x20
    '{1'b1, 4'd0,  10'h20, 1'b0}
  };

  function automatic logic [31:0] up_va(input logic [9:0] k);
    return {k, 22'h0};
  endfunction
  function automatic logic [31:0] lo_va(input logic [9:0] k);
    return {10'h3FF, k, 12'h0};
  endfunction
  function automatic logic [31:0] frm(input logic [9:0] k);
    return 32'hD000_0000 | {22'd0, k};
  endfunction

  task automatic check(input logic ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic cfg(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic fill(input logic arr, input logic [3:0] s, input logic [31:0] va,
                      input logic [31:0] d);
    @(negedge clk);
    fl_en = 1'b1; fl_arr = arr; fl_stream = s; fl_vaddr = va; fl_frame = d;
    @(negedge clk);
    fl_en = 1'b0;
  endtask

  task automatic look(input logic arr, input logic [3:0] s, input logic [31:0] va,
                      input logic eh, input logic [31:0] ed, input string req);
    lk_arr = arr; lk_stream = s; lk_vaddr = va;
    #1;
    check(lk_hit == eh, req, "hit", {31'd0, lk_hit}, {31'd0, eh});
    if (eh) check(lk_frame == ed, req, "frame", lk_frame, ed);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    check(cfg_err == 1'b0, "R1", "cfg_err", {31'd0, cfg_err}, 32'd0);
    look(1'b0, 4'd15, up_va(10'h11), 1'b0, 32'd0, "R1");
    fill(1'b1, 4'd0, lo_va(10'h3), 32'hBBBB_0003);
    look(1'b1, 4'd0,  lo_va(10'h3), 1'b0, 32'd0, "R1");
    look(1'b1, 4'd15, lo_va(10'h3), 1'b0, 32'd0, "R1");
    fill(1'b1, 4'd15, lo_va(10'h3), 32'hAAAA_0003);
    look(1'b1, 4'd15, lo_va(10'h3), 1'b1, 32'hAAAA_0003, "R1");

    // R2 array select and key field: [31:22]=0x11, [21:12]=3
    look(1'b1, 4'd15, 32'h0440_3000, 1'b1, 32'hAAAA_0003, "R2");
    look(1'b0, 4'd15, 32'h0440_3000, 1'b0, 32'd0, "R2");

    // Program upper-array starts
    for (int i = 1; i < 16; i++)
      cfg(8'(12 + 4 * i), (i == 1) ? 32'd4 : (i == 2) ? 32'd6 : 32'd8);

    for (int v = 0; v < NV; v++) begin
      if (!VECS[v].look)
        fill(1'b0, VECS[v].s, up_va(VECS[v].key), frm(VECS[v].key));
      else
        look(1'b0, VECS[v].s, up_va(VECS[v].key), VECS[v].eh, frm(VECS[v].key),
             $sformatf("R3-R7 vec%0d", v));
    end
    look(1'b0, 4'd0, up_va(10'h24), 1'b1, frm(10'h24), "R6");
    look(1'b0, 4'd0, up_va(10'h21), 1'b1, frm(10'h21), "R6");

    // R11 fill and lookup of the same key in one cycle
    @(negedge clk);
    fl_en = 1'b1; fl_arr = 1'b0; fl_stream = 4'd2; fl_vaddr = up_va(10'h40);
    fl_frame = frm(10'h40);
    look(1'b0, 4'd2, up_va(10'h40), 1'b0, 32'd0, "R11");
    @(negedge clk);
    fl_en = 1'b0;
    look(1'b0, 4'd2, up_va(10'h40), 1'b1, frm(10'h40), "R11");

    // R8 unmapped and misaligned offsets have no effect
    cfg(8'h08, 32'd0);
    cfg(8'h11, 32'd0);
    cfg(8'h8C, 32'd0);
    look(1'b0, 4'd0, up_va(10'h21), 1'b1, frm(10'h21), "R8");
    check(cfg_err == 1'b0, "R8", "cfg_err", {31'd0, cfg_err}, 32'd0);

    // R8 lower-array offsets: s15 start 16, s14 start 0
    cfg(8'h88, 32'd16);
    look(1'b1, 4'd15, lo_va(10'h3), 1'b0, 32'd0, "R8");
    cfg(8'h84, 32'd0);
    look(1'b1, 4'd14, lo_va(10'h3), 1'b1, 32'hAAAA_0003, "R8");

    // R9 boundary 31 accepted, 32 refused
    cfg(8'h88, 32'd31);
    check(cfg_err == 1'b0, "R9", "cfg_err after 31", {31'd0, cfg_err}, 32'd0);
    cfg(8'h88, 32'd16);
    cfg(8'h88, 32'd32);
    check(cfg_err == 1'b1, "R9", "cfg_err after 32", {31'd0, cfg_err}, 32'd1);
    fill(1'b1, 4'd15, lo_va(10'h7), 32'hCCCC_0007);
    look(1'b1, 4'd15, lo_va(10'h7), 1'b1, 32'hCCCC_0007, "R9");
    cfg(8'h88, 32'd16);
    check(cfg_err == 1'b1, "R9", "cfg_err sticky", {31'd0, cfg_err}, 32'd1);

    // R10 invalidate both arrays
    cfg(8'h00, 32'h5);
    look(1'b0, 4'd0,  up_va(10'h21), 1'b0, 32'd0, "R10");
    look(1'b1, 4'd14, lo_va(10'h3),  1'b0, 32'd0, "R10");
    look(1'b1, 4'd15, lo_va(10'h7),  1'b0, 32'd0, "R10");
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = 8'h00; cfg_wdata = 32'd0;
    fl_en = 1'b1; fl_arr = 1'b0; fl_stream = 4'd0; fl_vaddr = up_va(10'h50);
    fl_frame = frm(10'h50);
    @(negedge clk);
    cfg_we = 1'b0; fl_en = 1'b0;
    look(1'b0, 4'd0, up_va(10'h50), 1'b0, 32'd0, "R10");
    fill(1'b0, 4'd0, up_va(10'h50), frm(10'h50));
    look(1'b0, 4'd0, up_va(10'h50), 1'b1, frm(10'h50), "R10");

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule